// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block turns single-word requests from an on-chip requester into external bus cycles on a bus whose lower sixteen lines carry the address first and the data afterwards. There are three kinds of request: read, write and memory refresh. The block drives the address-latch strobe, a three-bit cycle status, the read and write strobes, the high-byte enable, a separate refresh strobe for narrow mode and the shared lines. Read data comes back on a holding register, and a one-clock done pulse marks the end of each read or write.

Every cycle runs four clock phases, T1 to T4. T1 carries the address, T2 and T3 carry the strobe, and T4 releases the strobe. A refresh cycle follows the read sequence exactly, but it marks itself through A0 and the byte enables and it returns no data. A width-select input picks a 16-bit bus, with two byte lanes, or an 8-bit bus, with the low lane only. The block samples it when it accepts a request.

Wait states, bus arbitration, chip-select decoding and the timing of refresh requests are handled outside. The refresh request arrives as a plain level input.

Top module: `mbus_cycle_seq`

## Requirements
- R1: In reset and when idle, all of the following hold: `ale`=0, `status`=3'b111, `rd_n`=`wr_n`=`bhe_n`=`rfsh_n`=1, `ad_oe`=2'b00, `done`=0, `a_hi`=0. A synchronous reset in mid-cycle returns the block to idle.
- R2: `ale` is high for exactly the T1 clock that follows acceptance. The non-passive status and `a_hi`=address bits above bit 15 are valid from T1 through T3. Status returns to 3'b111 in T4.
- R3: For a read, `rd_n` is low in T2 and T3. Lanes that carry data float from T2 to T4. `rd_data` is loaded at the edge that ends T3, and `done` is 1 during T4.
- R4: For a write, `wr_n` is low in T2 and T3. The write data is driven from T2 through T4, which is one clock after `wr_n` rises. `done` is 1 during T4 and `rd_data` is unchanged.
- R5: The status code is 3'b101 for a read or a refresh and 3'b110 for a write.
- R6: A refresh on the 16-bit bus drives A0 (`ad_out[0]` in T1) to 1 and keeps `bhe_n` high. It uses the read strobe timing, leaves `rd_data` unchanged and gives no `done`.
- R7: A refresh on the 8-bit bus drives A0 to 1 and drives `rfsh_n` low from T1 to T3, the window in which `bhe_n` would be low. `bhe_n` stays high, and `rfsh_n` never falls on the 16-bit bus.
- R8: For a 16-bit byte access to an odd address, A0=1 and `bhe_n`=0. Write data is replicated on both lanes. A read returns `ad_in[15:8]` zero-extended.
- R9: For a 16-bit word access, A0=0 and `bhe_n`=0. All 16 bits are transferred.
- R10: For a 16-bit byte access to an even address, A0=0 and `bhe_n`=1. A read returns `ad_in[7:0]` zero-extended.
- R11: On the 8-bit bus, A0 follows address bit 0 and `bhe_n` stays high. Data uses the low lane only. The upper lane keeps driving address bits 15:8 through T4, so `ad_oe`=2'b10 in the data phase of a read.
- R12: A request is accepted (`req_ack`=1) only when the block is idle or in T4, with the priority refresh > write > read. An acceptance in T4 is followed directly by the next T1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus16 | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus; sampled when a request is accepted |
| req_rd | input | 1 | Read request |
| req_wr | input | 1 | Write request |
| req_rfsh | input | 1 | Refresh request |
| req_byte | input | 1 | 1 = byte access, 0 = word access (16-bit bus only) |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data (byte in bits 7:0) |
| req_ack | output | 1 | Request accepted this clock |
| ale | output | 1 | Address latch strobe, high in T1 |
| status | output | 3 | Cycle status code |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| bhe_n | output | 1 | High-byte enable, active low |
| rfsh_n | output | 1 | Refresh strobe for the 8-bit bus, active low |
| a_hi | output | AW-DW | Upper address lines |
| ad_out | output | DW | Address/data lines, driven value |
| ad_oe | output | 2 | Per-lane output enable (bit 1 = upper lane) |
| ad_in | input | DW | Address/data lines, sampled value |
| rd_data | output | DW | Last read data |
| done | output | 1 | One-clock pulse in T4 of a read or write |

## Verification
The checker watches every cycle for several rules. `ale` lasts one clock, and the status is never passive while `ale` is high. The two strobes are never low together, and a read never drives the low lane. Write data is still driven in the clock after `wr_n` rises. `done` follows only a strobe release. `rfsh_n` and `bhe_n` are never active together, and acceptance happens only while both strobes are idle. The bench scenarios cover the rest: the exact A0, byte-enable and lane values for each bus width and access size, the zero-extension of read data, the fact that a refresh leaves the read data alone, the request priority and back-to-back cycles from T4.

// File: rtl/mbus_pkg.sv
// Package: shared types and status codes for the multiplexed bus sequencer.
// Assumes a four-phase cycle and a three-bit status bus.
package mbus_pkg;

    typedef enum logic [1:0] {
        K_READ    = 2'd0,
        K_WRITE   = 2'd1,
        K_REFRESH = 2'd2
    } kind_e;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_T4   = 3'd4
    } phase_e;

    localparam logic [2:0] ST_MEM_RD  = 3'b101;
    localparam logic [2:0] ST_MEM_WR  = 3'b110;
    localparam logic [2:0] ST_PASSIVE = 3'b111;

endpackage

// File: rtl/mbus_req_arb.sv
// Module: fixed-priority request selection (refresh > write > read).
// Assumes the caller says when a new cycle may start via 'free'.
module mbus_req_arb
    import mbus_pkg::*;
(
    input  logic  free,
    input  logic  req_rfsh,
    input  logic  req_wr,
    input  logic  req_rd,
    output logic  take,
    output kind_e take_kind
);

    // Pick the winning request and decide acceptance.
    always_comb begin
        take = free && (req_rfsh || req_wr || req_rd);
        if (req_rfsh)    take_kind = K_REFRESH;
        else if (req_wr) take_kind = K_WRITE;
        else             take_kind = K_READ;
    end

endmodule

// File: rtl/mbus_phase_ctl.sv
// Module: phase sequencer T1..T4 with request capture.
// Assumes a new request is only offered through 'take' when 'free' is high.
module mbus_phase_ctl
    import mbus_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  kind_e         take_kind,
    input  logic          take_bus16,
    input  logic          take_byte,
    input  logic [AW-1:0] take_addr,
    input  logic [DW-1:0] take_wdata,
    output phase_e        phase,
    output logic          free,
    output kind_e         cur_kind,
    output logic          cur_bus16,
    output logic          cur_byte,
    output logic [AW-1:0] cur_addr,
    output logic [DW-1:0] cur_wdata
);

    phase_e phase_q;
    phase_e phase_d;

    // Next-phase decode: fixed four-phase walk, restart only from idle or T4.
    always_comb begin
        case (phase_q)
            PH_T1:   phase_d = PH_T2;
            PH_T2:   phase_d = PH_T3;
            PH_T3:   phase_d = PH_T4;
            default: phase_d = take ? PH_T1 : PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Capture the accepted request for the whole cycle (and T4 hold).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_kind  <= K_READ;
            cur_bus16 <= 1'b1;
            cur_byte  <= 1'b0;
            cur_addr  <= '0;
            cur_wdata <= '0;
        end else if (take) begin
            cur_kind  <= take_kind;
            cur_bus16 <= take_bus16;
            cur_byte  <= take_byte;
            cur_addr  <= take_addr;
            cur_wdata <= take_wdata;
        end
    end

    assign phase = phase_q;
    assign free  = (phase_q == PH_IDLE) || (phase_q == PH_T4);

endmodule

// File: rtl/mbus_pin_map.sv
// Module: decodes phase and captured request into external pin values.
// Assumes DW is two byte lanes and AW > DW.
module mbus_pin_map
    import mbus_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  phase_e           phase,
    input  kind_e            cur_kind,
    input  logic             cur_bus16,
    input  logic             cur_byte,
    input  logic [AW-1:0]    cur_addr,
    input  logic [DW-1:0]    cur_wdata,
    output logic             ale,
    output logic [2:0]       status,
    output logic             rd_n,
    output logic             wr_n,
    output logic             bhe_n,
    output logic             rfsh_n,
    output logic [AW-DW-1:0] a_hi,
    output logic [DW-1:0]    ad_out,
    output logic [1:0]       ad_oe
);

    localparam int LW = DW / 2;

    logic addr_ph, data_ph, strobe_ph, held_ph;
    logic is_rf, is_wr;
    logic a0_val, bhe_act, rfsh_act;

    // Phase windows and request class.
    always_comb begin
        addr_ph   = (phase == PH_T1);
        strobe_ph = (phase == PH_T2) || (phase == PH_T3);
        data_ph   = strobe_ph || (phase == PH_T4);
        held_ph   = addr_ph || strobe_ph;
        is_rf     = (cur_kind == K_REFRESH);
        is_wr     = (cur_kind == K_WRITE);
    end

    // A0, high-byte enable and refresh strobe selection per width and size.
    always_comb begin
        if (is_rf)                      a0_val = 1'b1;
        else if (!cur_bus16 || cur_byte) a0_val = cur_addr[0];
        else                            a0_val = 1'b0;
        bhe_act  = cur_bus16 && !is_rf && (!cur_byte || cur_addr[0]);
        rfsh_act = !cur_bus16 && is_rf;
    end

    // Control strobes and status.
    always_comb begin
        ale    = addr_ph;
        status = held_ph ? (is_wr ? ST_MEM_WR : ST_MEM_RD) : ST_PASSIVE;
        rd_n   = !(strobe_ph && !is_wr);
        wr_n   = !(strobe_ph && is_wr);
        bhe_n  = !(held_ph && bhe_act);
        rfsh_n = !(held_ph && rfsh_act);
        a_hi   = held_ph ? cur_addr[AW-1:DW] : '0;
    end

    // Shared-line value: address in T1, lane-mapped data afterwards.
    always_comb begin
        ad_out = '0;
        if (addr_ph) begin
            ad_out = {cur_addr[DW-1:1], a0_val};
        end else if (data_ph) begin
            if (is_wr && cur_bus16 && !cur_byte)
                ad_out = cur_wdata;
            else if (is_wr && cur_bus16)
                ad_out = {cur_wdata[LW-1:0], cur_wdata[LW-1:0]};
            else if (is_wr)
                ad_out = {cur_addr[DW-1:LW], cur_wdata[LW-1:0]};
            else if (!cur_bus16)
                ad_out = {cur_addr[DW-1:LW], {LW{1'b0}}};
        end
    end

    // Per-lane output enable; the upper lane keeps the address on the 8-bit bus.
    for (genvar ln = 0; ln < 2; ln++) begin : g_lane
        always_comb begin
            ad_oe[ln] = addr_ph ||
                        (data_ph && (is_wr || (!cur_bus16 && (ln != 0))));
        end
    end

endmodule

// File: rtl/mbus_rdata_cap.sv
// Module: read-data capture at the end of T3 and the done pulse in T4.
// Assumes ad_in is stable at the T3 closing edge; refresh data is dropped.
module mbus_rdata_cap
    import mbus_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_e        phase,
    input  kind_e         cur_kind,
    input  logic          cur_bus16,
    input  logic          cur_byte,
    input  logic          cur_a0,
    input  logic [DW-1:0] ad_in,
    output logic [DW-1:0] rd_data,
    output logic          done
);

    localparam int LW = DW / 2;

    logic [DW-1:0] sel;

    // Lane selection and zero-extension of the returned value.
    always_comb begin
        if (cur_bus16 && !cur_byte)        sel = ad_in;
        else if (cur_bus16 && cur_a0)      sel = {{LW{1'b0}}, ad_in[DW-1:LW]};
        else                               sel = {{LW{1'b0}}, ad_in[LW-1:0]};
    end

    // Load read data at the T3 closing edge; flag done for reads and writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            done    <= 1'b0;
        end else begin
            done <= (phase == PH_T3) && (cur_kind != K_REFRESH);
            if ((phase == PH_T3) && (cur_kind == K_READ))
                rd_data <= sel;
        end
    end

endmodule

// File: rtl/mbus_cycle_seq.sv
// Module: top of the multiplexed bus cycle sequencer.
// Assumes one outstanding request at a time, no wait states, DW = 16.
module mbus_cycle_seq
    import mbus_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus16,
    input  logic             req_rd,
    input  logic             req_wr,
    input  logic             req_rfsh,
    input  logic             req_byte,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             req_ack,
    output logic             ale,
    output logic [2:0]       status,
    output logic             rd_n,
    output logic             wr_n,
    output logic             bhe_n,
    output logic             rfsh_n,
    output logic [AW-DW-1:0] a_hi,
    output logic [DW-1:0]    ad_out,
    output logic [1:0]       ad_oe,
    input  logic [DW-1:0]    ad_in,
    output logic [DW-1:0]    rd_data,
    output logic             done
);

    logic          free, take;
    kind_e         take_kind, cur_kind;
    phase_e        phase;
    logic          cur_bus16, cur_byte;
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] cur_wdata;

    mbus_req_arb u_arb (
        .free      (free),
        .req_rfsh  (req_rfsh),
        .req_wr    (req_wr),
        .req_rd    (req_rd),
        .take      (take),
        .take_kind (take_kind)
    );

    mbus_phase_ctl #(.AW(AW), .DW(DW)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .take_kind  (take_kind),
        .take_bus16 (bus16),
        .take_byte  (req_byte),
        .take_addr  (req_addr),
        .take_wdata (req_wdata),
        .phase      (phase),
        .free       (free),
        .cur_kind   (cur_kind),
        .cur_bus16  (cur_bus16),
        .cur_byte   (cur_byte),
        .cur_addr   (cur_addr),
        .cur_wdata  (cur_wdata)
    );

    mbus_pin_map #(.AW(AW), .DW(DW)) u_pins (
        .phase     (phase),
        .cur_kind  (cur_kind),
        .cur_bus16 (cur_bus16),
        .cur_byte  (cur_byte),
        .cur_addr  (cur_addr),
        .cur_wdata (cur_wdata),
        .ale       (ale),
        .status    (status),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .bhe_n     (bhe_n),
        .rfsh_n    (rfsh_n),
        .a_hi      (a_hi),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe)
    );

    mbus_rdata_cap #(.DW(DW)) u_rcap (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .cur_kind  (cur_kind),
        .cur_bus16 (cur_bus16),
        .cur_byte  (cur_byte),
        .cur_a0    (cur_addr[0]),
        .ad_in     (ad_in),
        .rd_data   (rd_data),
        .done      (done)
    );

    assign req_ack = take;

endmodule

// File: rtl/mbus_cycle_seq_chk.sv
// Module: protocol checker bound to mbus_cycle_seq.
// Assumes the synchronous active-low reset of the top.
module mbus_cycle_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ack,
    input logic       ale,
    input logic [2:0] status,
    input logic       rd_n,
    input logic       wr_n,
    input logic       bhe_n,
    input logic       rfsh_n,
    input logic [1:0] ad_oe,
    input logic       done
);

    assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    assert_ale_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (status != 3'b111));

    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    assert_read_float_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe[0]);

    assert_write_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> ad_oe[0]);

    assert_done_after_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($rose(rd_n) || $rose(wr_n)));

    assert_rfsh_bhe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rfsh_n && !bhe_n));

    assert_rfsh_no_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rfsh_n) |-> !done);

    assert_ack_when_free_R12: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> (rd_n && wr_n && !ale));

endmodule

bind mbus_cycle_seq mbus_cycle_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_ack (req_ack),
    .ale     (ale),
    .status  (status),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .bhe_n   (bhe_n),
    .rfsh_n  (rfsh_n),
    .ad_oe   (ad_oe),
    .done    (done)
);

// File: tb/mbus_cycle_seq_bench.sv
module mbus_cycle_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 20;
    localparam int DW = 16;

    // kind: 0 read, 1 write, 2 refresh
    typedef struct packed {
        logic [1:0]  kind;
        logic        b16;
        logic        byt;
        logic [15:0] addr;
        logic [15:0] wdata;
        logic [15:0] rdin;
        logic [15:0] t1ad;
        logic        bhe;
        logic        rfsh;
        logic [2:0]  st;
        logic [1:0]  oe2;
        logic [15:0] wd;
        logic [15:0] rd;
        logic        dn;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        // R9 word read, 16-bit
        '{2'd0,1'b1,1'b0,16'h1234,16'h0000,16'hBEEF,16'h1234,1'b0,1'b1,3'b101,2'b00,16'h0000,16'hBEEF,1'b1},
        // R9 word write, 16-bit
        '{2'd1,1'b1,1'b0,16'h2000,16'hA55A,16'h0000,16'h2000,1'b0,1'b1,3'b110,2'b11,16'hA55A,16'h0000,1'b1},
        // R8 odd byte read
        '{2'd0,1'b1,1'b1,16'h0101,16'h0000,16'h7E11,16'h0101,1'b0,1'b1,3'b101,2'b00,16'h0000,16'h007E,1'b1},
        // R10 even byte read
        '{2'd0,1'b1,1'b1,16'h0100,16'h0000,16'h7E11,16'h0100,1'b1,1'b1,3'b101,2'b00,16'h0000,16'h0011,1'b1},
        // R8 odd byte write
        '{2'd1,1'b1,1'b1,16'h0303,16'h00C3,16'h0000,16'h0303,1'b0,1'b1,3'b110,2'b11,16'hC3C3,16'h0000,1'b1},
        // R11 8-bit write
        '{2'd1,1'b0,1'b0,16'h4567,16'h005A,16'h0000,16'h4567,1'b1,1'b1,3'b110,2'b11,16'h455A,16'h0000,1'b1},
        // R11 8-bit read
        '{2'd0,1'b0,1'b0,16'h4566,16'h0000,16'h99AB,16'h4566,1'b1,1'b1,3'b101,2'b10,16'h0000,16'h00AB,1'b1},
        // R6 refresh, 16-bit
        '{2'd2,1'b1,1'b0,16'h0010,16'h0000,16'hFFFF,16'h0011,1'b1,1'b1,3'b101,2'b00,16'h0000,16'h0000,1'b0},
        // R7 refresh, 8-bit
        '{2'd2,1'b0,1'b0,16'h0020,16'h0000,16'h1234,16'h0021,1'b1,1'b0,3'b101,2'b10,16'h0000,16'h0000,1'b0},
        // R10 even byte write
        '{2'd1,1'b1,1'b1,16'h0302,16'h00C3,16'h0000,16'h0302,1'b1,1'b1,3'b110,2'b11,16'hC3C3,16'h0000,1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus16 = 1'b1;
    logic          req_rd = 1'b0, req_wr = 1'b0, req_rfsh = 1'b0, req_byte = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [DW-1:0] ad_in = '0;
    logic          req_ack, ale, rd_n, wr_n, bhe_n, rfsh_n, done;
    logic [2:0]    status;
    logic [AW-DW-1:0] a_hi;
    logic [DW-1:0] ad_out, rd_data;
    logic [1:0]    ad_oe;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [15:0] rd_model = 16'h0000;

    mbus_cycle_seq #(.AW(AW), .DW(DW)) u_mbus_cycle_seq (
        .clk(clk), .rst_n(rst_n), .bus16(bus16),
        .req_rd(req_rd), .req_wr(req_wr), .req_rfsh(req_rfsh),
        .req_byte(req_byte), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ack(req_ack), .ale(ale), .status(status), .rd_n(rd_n),
        .wr_n(wr_n), .bhe_n(bhe_n), .rfsh_n(rfsh_n), .a_hi(a_hi),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
        .rd_data(rd_data), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_checks(input string tag);
        check({tag, " ale"}, ale, 0);
        check({tag, " status"}, status, 3'b111);
        check({tag, " rd_n"}, rd_n, 1);
        check({tag, " wr_n"}, wr_n, 1);
        check({tag, " bhe_n"}, bhe_n, 1);
        check({tag, " rfsh_n"}, rfsh_n, 1);
        check({tag, " ad_oe"}, ad_oe, 0);
        check({tag, " done"}, done, 0);
        check({tag, " a_hi"}, a_hi, 0);
    endtask

    task automatic drop_reqs();
        req_rd = 0; req_wr = 0; req_rfsh = 0;
    endtask

    // One full cycle from idle, checked phase by phase.
    task automatic run_vec(input vec_t v);
        @(negedge clk);
        bus16 = v.b16; req_byte = v.byt;
        req_addr = {4'h5, v.addr}; req_wdata = v.wdata;
        req_rd = (v.kind == 2'd0); req_wr = (v.kind == 2'd1); req_rfsh = (v.kind == 2'd2);
        #1 check("R12 ack in idle", req_ack, 1);
        @(negedge clk); drop_reqs();
        #1;
        check("R2 ale T1", ale, 1);
        check("R5 status T1", status, v.st);
        check("R8/R9/R10/R11/R6 T1 address and A0", ad_out, v.t1ad);
        check("R2 T1 lanes driven", ad_oe, 2'b11);
        check("R8/R9/R10/R6 bhe_n T1", bhe_n, v.bhe);
        check("R7 rfsh_n T1", rfsh_n, v.rfsh);
        check("R2 a_hi T1", a_hi, 4'h5);
        @(negedge clk); ad_in = v.rdin;
        #1;
        check("R2 ale T2", ale, 0);
        check("R3 rd_n T2", rd_n, (v.kind == 2'd1) ? 1'b1 : 1'b0);
        check("R4 wr_n T2", wr_n, (v.kind == 2'd1) ? 1'b0 : 1'b1);
        check("R3/R4/R11 lanes T2", ad_oe, v.oe2);
        if (v.kind == 2'd1) check("R4/R8/R11 write data T2", ad_out, v.wd);
        check("R7/R8 bhe_n T2", bhe_n, v.bhe);
        check("R7 rfsh_n T2", rfsh_n, v.rfsh);
        check("R5 status T2", status, v.st);
        @(negedge clk); #1;
        check("R3/R4 strobe T3", rd_n & wr_n, 0);
        check("R7 rfsh_n T3", rfsh_n, v.rfsh);
        @(negedge clk); #1;
        if (v.kind == 2'd0) rd_model = v.rd;
        check("R3/R4 strobes released T4", rd_n & wr_n, 1);
        check("R2 status passive T4", status, 3'b111);
        check("R3/R4/R6 done T4", done, v.dn);
        check("R3/R6/R8/R10 rd_data T4", rd_data, rd_model);
        check("R7 rfsh_n T4", rfsh_n, 1);
        check("R3/R4/R11 lanes T4", ad_oe, v.oe2);
        if (v.kind == 2'd1) check("R4 write data held T4", ad_out, v.wd);
        @(negedge clk); #1;
        idle_checks("R1 idle after cycle");
    endtask

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        #1 idle_checks("R1 in reset");
        rst_n = 1;
        @(negedge clk); #1 idle_checks("R1 after reset");

        for (int i = 0; i < NV; i++) run_vec(TBL[i]);

        // R12 priority: all three at once, refresh wins (16-bit, even word address)
        @(negedge clk);
        bus16 = 1; req_byte = 0; req_addr = 20'h50100;
        req_rd = 1; req_wr = 1; req_rfsh = 1;
        #1 check("R12 ack", req_ack, 1);
        @(negedge clk); drop_reqs();
        #1;
        check("R12 refresh wins status", status, 3'b101);
        check("R12/R6 refresh wins A0", ad_out[0], 1);
        check("R12/R6 refresh wins bhe_n", bhe_n, 1);
        repeat (3) @(negedge clk);
        #1 check("R6 no done after priority refresh", done, 0);

        // R12 write beats read, then back-to-back read from T4
        @(negedge clk);
        req_wr = 1; req_rd = 1; req_wdata = 16'h1357; req_addr = 20'h50200;
        #1 check("R12 ack write/read", req_ack, 1);
        @(negedge clk); req_wr = 0;
        #1 check("R12 write wins status", status, 3'b110);
        @(negedge clk);
        #1 check("R12 no ack in T2", req_ack, 0);
        @(negedge clk);
        #1 check("R12 no ack in T3", req_ack, 0);
        @(negedge clk);
        #1 check("R12 ack in T4", req_ack, 1);
        check("R4 done write T4", done, 1);
        @(negedge clk); drop_reqs();
        #1;
        check("R12 back-to-back ale", ale, 1);
        check("R12 back-to-back status", status, 3'b101);

        // R1 mid-cycle reset
        @(negedge clk); rst_n = 0;
        @(negedge clk); #1 idle_checks("R1 mid-cycle reset");
        rst_n = 1;
        @(negedge clk); #1 idle_checks("R1 idle after mid reset");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: counts as a failed check and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule